// File: doc/BRIEF.md
# Byte-Walking Partial-Word Load/Store Merger

This block runs the memory half of the sub-word and unaligned load and store operations of a little-endian 32-bit core. The core hands it one command: an operation code, an effective byte address, the current value of the destination register, the index of that register and the data to store. The block then steps through memory one byte per cycle on a byte-wide port. When it is done it returns the register value the core should write back.

The left and right forms walk from the effective address toward a word boundary. Each step fills or emits one byte lane, so the number of bytes moved (one to four) depends on the two low address bits. Loaded register lanes that the walk does not visit keep their old value. Byte and halfword loads are extended to 32 bits, either signed or unsigned. Byte and halfword stores write their low bytes. A read returns its data one cycle after the address is presented. A one-cycle done pulse marks the end of each command.

Top module: `bytewalk_merger`

## Requirements
- R1: After reset, `busy`, `done` and `mem_en` are low, and the block accepts a command on the first cycle that `start` is high.
- R2: Opcode 4 (load-left) writes the byte at the effective address into register bits [31:24]. It then moves down one address and eight bits per step and stops after the byte whose address ends in binary 00, so it moves (address[1:0] + 1) bytes.
- R3: Opcode 5 (load-right) writes the byte at the effective address into bits [7:0]. It then moves up one address and eight bits per step and stops after the byte whose address ends in binary 11, so it moves (4 - address[1:0]) bytes.
- R4: Opcode 8 (store-left) writes store-data bits [31:24] to the effective address, then bits [23:16] one address lower, and so on. It stops after writing an address that ends in binary 00.
- R5: Opcode 9 (store-right) writes store-data bits [7:0] to the effective address, then bits [15:8] one address higher, and so on. It stops after writing an address that ends in binary 11.
- R6: For load-left and load-right, register bytes not visited by the walk keep the value given on `reg_old`.
- R7: For every load opcode (0 to 5), a destination index of 0 gives a result of zero.
- R8: Opcode 0 loads one byte and sign-extends it from bit 7. Opcode 1 zero-extends it. Opcode 2 loads a halfword and sign-extends it from bit 15. Opcode 3 zero-extends it. A halfword ignores address bit 0: its low byte comes from the even address and its high byte from the next address.
- R9: Opcode 6 writes store-data [7:0] to the effective address. Opcode 7 writes [7:0] to the even address and [15:8] to the next address. For all stores, `result` returns `reg_old` unchanged.
- R10: During every access, `mem_lane` equals 1 shifted left by `mem_addr[1:0]`. It is zero when no access is made.
- R11: `mem_rdata` is taken one cycle after its address. `done` is high for exactly one cycle after the last byte, and `result` holds its value until the next command completes.
- R12: `start` is ignored while `busy` is high, and opcodes 10 to 15 are ignored. An ignored command makes no memory access and raises neither `busy` nor `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Command request, taken when idle |
| op | input | 4 | Operation code |
| eff_addr | input | ADDR_W | Effective byte address |
| reg_old | input | 32 | Current destination register value |
| store_data | input | 32 | Register value to store |
| dst_idx | input | IDX_W | Destination register index |
| busy | output | 1 | Command in progress |
| mem_en | output | 1 | Memory access this cycle |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | ADDR_W | Byte address of the access |
| mem_lane | output | 4 | One-hot lane of the byte within its word |
| mem_wdata | output | 8 | Byte to write |
| mem_rdata | input | 8 | Byte read, valid one cycle after its address |
| done | output | 1 | One-cycle completion pulse |
| result | output | 32 | Merged register value |

## Verification
The bench runs every left and right form from all four byte offsets. Getting the stop condition wrong by one shows up as a wrong byte count and as a corrupted neighbouring byte in memory. A wrong lane order or direction would swap bytes in the register, and a lost old-value merge would zero the lanes that were not visited. The bench covers sign and zero extension with the top bit both set and clear, halfwords at odd addresses, and a zero destination index. It also drives commands while the block is busy and commands with undefined codes; either one, if accepted, would alter memory or raise `done`.

// File: rtl/bwm_pkg.sv
package bwm_pkg;

    localparam int WORD_W  = 32;
    localparam int LANES   = WORD_W / 8;
    localparam int LANE_W  = $clog2(LANES);

    typedef enum logic [3:0] {
        OP_LB  = 4'd0,
        OP_LBU = 4'd1,
        OP_LH  = 4'd2,
        OP_LHU = 4'd3,
        OP_LWL = 4'd4,
        OP_LWR = 4'd5,
        OP_SB  = 4'd6,
        OP_SH  = 4'd7,
        OP_SWL = 4'd8,
        OP_SWR = 4'd9
    } bwm_op_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_WALK  = 2'd1,
        ST_DRAIN = 2'd2
    } bwm_state_e;

    function automatic logic op_known(input logic [3:0] code);
        return code <= 4'd9;
    endfunction

    function automatic logic op_store(input bwm_op_e code);
        return code inside {OP_SB, OP_SH, OP_SWL, OP_SWR};
    endfunction

    function automatic logic op_down(input bwm_op_e code);
        return code inside {OP_LWL, OP_SWL};
    endfunction

    function automatic logic op_half(input bwm_op_e code);
        return code inside {OP_LH, OP_LHU, OP_SH};
    endfunction

    function automatic logic op_keeps_old(input bwm_op_e code);
        return !(code inside {OP_LB, OP_LBU, OP_LH, OP_LHU});
    endfunction

    function automatic logic [LANE_W-1:0] first_lane(input bwm_op_e code);
        return (code inside {OP_LWL, OP_SWL}) ? LANE_W'(LANES - 1) : '0;
    endfunction

    // Walk termination depends on the byte offset within the word
    function automatic logic step_last(input bwm_op_e code, input logic [1:0] ofs);
        case (code)
            OP_LB, OP_LBU, OP_SB:   return 1'b1;
            OP_LH, OP_LHU, OP_SH:   return ofs[0];
            OP_LWL, OP_SWL:         return ofs == 2'b00;
            OP_LWR, OP_SWR:         return ofs == 2'b11;
            default:                return 1'b1;
        endcase
    endfunction

    function automatic logic [WORD_W-1:0] extend(input bwm_op_e code, input logic [WORD_W-1:0] v);
        case (code)
            OP_LB:   return {{24{v[7]}}, v[7:0]};
            OP_LBU:  return {24'd0, v[7:0]};
            OP_LH:   return {{16{v[15]}}, v[15:0]};
            OP_LHU:  return {16'd0, v[15:0]};
            default: return v;
        endcase
    endfunction

endpackage

// File: rtl/bwm_walker.sv
module bwm_walker
    import bwm_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [3:0]        op,
    input  logic [ADDR_W-1:0] eff_addr,
    input  logic [WORD_W-1:0] store_data,
    output logic              accept,
    output logic              busy,
    output logic              mem_en,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [LANES-1:0]  mem_lane,
    output logic [7:0]        mem_wdata,
    output logic              cap_valid,
    output logic [LANE_W-1:0] cap_lane,
    output logic              finish_now,
    output bwm_op_e           op_q
);

    localparam logic [ADDR_W-1:0] ONE = ADDR_W'(1);

    bwm_state_e          st;
    logic [ADDR_W-1:0]   cur_addr;
    logic [LANE_W-1:0]   lane_q;
    logic [WORD_W-1:0]   sdata_q;
    logic                pend_v;
    logic [LANE_W-1:0]   pend_lane;
    logic                last;
    bwm_op_e             op_in;

    assign op_in      = bwm_op_e'(op);
    assign accept     = start && (st == ST_IDLE) && op_known(op);
    assign busy       = (st != ST_IDLE);
    assign mem_en     = (st == ST_WALK);
    assign mem_we     = mem_en && op_store(op_q);
    assign mem_addr   = cur_addr;
    assign mem_lane   = mem_en ? (LANES'(1) << cur_addr[1:0]) : '0;
    assign mem_wdata  = sdata_q[{lane_q, 3'b000} +: 8];
    assign last       = step_last(op_q, cur_addr[1:0]);
    assign cap_valid  = pend_v;
    assign cap_lane   = pend_lane;
    assign finish_now = ((st == ST_WALK) && last && op_store(op_q)) || (st == ST_DRAIN);

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= ST_IDLE;
            op_q      <= OP_LB;
            cur_addr  <= '0;
            lane_q    <= '0;
            sdata_q   <= '0;
            pend_v    <= 1'b0;
            pend_lane <= '0;
        end else begin
            case (st)
                ST_IDLE: begin
                    pend_v <= 1'b0;
                    if (accept) begin
                        op_q     <= op_in;
                        cur_addr <= op_half(op_in) ? (eff_addr & ~ONE) : eff_addr;
                        lane_q   <= first_lane(op_in);
                        sdata_q  <= store_data;
                        st       <= ST_WALK;
                    end
                end
                ST_WALK: begin
                    pend_v    <= !op_store(op_q);
                    pend_lane <= lane_q;
                    if (last) begin
                        st <= op_store(op_q) ? ST_IDLE : ST_DRAIN;
                    end else if (op_down(op_q)) begin
                        cur_addr <= cur_addr - ONE;
                        lane_q   <= lane_q - LANE_W'(1);
                    end else begin
                        cur_addr <= cur_addr + ONE;
                        lane_q   <= lane_q + LANE_W'(1);
                    end
                end
                default: begin
                    pend_v <= 1'b0;
                    st     <= ST_IDLE;
                end
            endcase
        end
    end

    // Consecutive accesses of one walk are adjacent bytes (R2, R3, R4, R5)
    p_adjacent_step_r2: assert property (@(posedge clk) disable iff (rst)
        (mem_en && $past(mem_en)) |->
            (mem_addr == $past(mem_addr) + ONE) || (mem_addr == $past(mem_addr) - ONE));

    // Lane strobe is one-hot while accessing (R10)
    p_lane_onehot_r10: assert property (@(posedge clk) disable iff (rst)
        mem_en |-> $onehot(mem_lane));

    // A walk never leaves its word (R2, R3)
    p_same_word_r3: assert property (@(posedge clk) disable iff (rst)
        (mem_en && $past(mem_en)) |-> (mem_addr[ADDR_W-1:2] == $past(mem_addr[ADDR_W-1:2])));

endmodule

// File: rtl/bwm_accum.sv
module bwm_accum
    import bwm_pkg::*;
#(
    parameter int IDX_W = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              accept,
    input  logic [3:0]        op,
    input  logic [WORD_W-1:0] reg_old,
    input  logic [IDX_W-1:0]  dst_idx,
    input  logic              cap_valid,
    input  logic [LANE_W-1:0] cap_lane,
    input  logic [7:0]        rdata,
    input  logic              finish_now,
    input  bwm_op_e           op_q,
    output logic              done,
    output logic [WORD_W-1:0] result
);

    logic [IDX_W-1:0]  dst_q;
    logic [WORD_W-1:0] merged;
    logic [WORD_W-1:0] final_val;
    logic [WORD_W-1:0] init_val;

    assign init_val = op_keeps_old(bwm_op_e'(op)) ? reg_old : '0;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [7:0] byte_q;
        logic       hit;
        assign hit = cap_valid && (cap_lane == LANE_W'(g));
        always_ff @(posedge clk) begin
            if (rst)
                byte_q <= '0;
            else if (accept)
                byte_q <= init_val[g*8 +: 8];
            else if (hit)
                byte_q <= rdata;
        end
        assign merged[g*8 +: 8] = hit ? rdata : byte_q;
    end

    always_comb begin
        final_val = extend(op_q, merged);
        if (!op_store(op_q) && (dst_q == '0))
            final_val = '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            dst_q  <= '0;
            done   <= 1'b0;
            result <= '0;
        end else begin
            if (accept)
                dst_q <= dst_idx;
            done <= finish_now;
            if (finish_now)
                result <= final_val;
        end
    end

    // Completion pulse lasts one cycle (R11)
    p_done_pulse_r11: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // Loads into index zero yield zero (R7)
    p_zero_dst_r7: assert property (@(posedge clk) disable iff (rst)
        (done && !op_store(op_q) && (dst_q == '0)) |-> (result == '0));

endmodule

// File: rtl/bytewalk_merger.sv
module bytewalk_merger
    import bwm_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int IDX_W  = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [3:0]        op,
    input  logic [ADDR_W-1:0] eff_addr,
    input  logic [31:0]       reg_old,
    input  logic [31:0]       store_data,
    input  logic [IDX_W-1:0]  dst_idx,
    output logic              busy,
    output logic              mem_en,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [3:0]        mem_lane,
    output logic [7:0]        mem_wdata,
    input  logic [7:0]        mem_rdata,
    output logic              done,
    output logic [31:0]       result
);

    logic              accept;
    logic              cap_valid;
    logic [LANE_W-1:0] cap_lane;
    logic              finish_now;
    bwm_op_e           op_q;

    bwm_walker #(.ADDR_W(ADDR_W)) u_walker (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .op         (op),
        .eff_addr   (eff_addr),
        .store_data (store_data),
        .accept     (accept),
        .busy       (busy),
        .mem_en     (mem_en),
        .mem_we     (mem_we),
        .mem_addr   (mem_addr),
        .mem_lane   (mem_lane),
        .mem_wdata  (mem_wdata),
        .cap_valid  (cap_valid),
        .cap_lane   (cap_lane),
        .finish_now (finish_now),
        .op_q       (op_q)
    );

    bwm_accum #(.IDX_W(IDX_W)) u_accum (
        .clk        (clk),
        .rst        (rst),
        .accept     (accept),
        .op         (op),
        .reg_old    (reg_old),
        .dst_idx    (dst_idx),
        .cap_valid  (cap_valid),
        .cap_lane   (cap_lane),
        .rdata      (mem_rdata),
        .finish_now (finish_now),
        .op_q       (op_q),
        .done       (done),
        .result     (result)
    );

    // No access outside a command (R1, R12)
    p_idle_quiet_r12: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !mem_en);

    // Completion is reported from the idle state (R11)
    p_done_idle_r11: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

    // Writes only happen as part of an access (R4, R5)
    p_write_in_access_r4: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> mem_en);

endmodule

// File: tb/bytewalk_merger_bench.sv
module bytewalk_merger_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [3:0]  op = 4'd0;
    logic [31:0] eff_addr = '0;
    logic [31:0] reg_old = '0;
    logic [31:0] store_data = '0;
    logic [4:0]  dst_idx = '0;
    logic        busy, mem_en, mem_we, done;
    logic [31:0] mem_addr, result;
    logic [3:0]  mem_lane;
    logic [7:0]  mem_wdata;
    logic [7:0]  mem_rdata = '0;

    int tests = 0;
    int fails = 0;
    int cycles = 0;

    logic [7:0] mem [16];
    logic [7:0] exp_mem [16];

    always #2.5 clk = ~clk;

    bytewalk_merger u_bytewalk_merger (
        .clk(clk), .rst(rst), .start(start), .op(op), .eff_addr(eff_addr),
        .reg_old(reg_old), .store_data(store_data), .dst_idx(dst_idx),
        .busy(busy), .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_lane(mem_lane), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .done(done), .result(result)
    );

    always @(posedge clk) begin
        if (mem_en && mem_we) mem[mem_addr[3:0]] <= mem_wdata;
        mem_rdata <= mem[mem_addr[3:0]];
    end

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    function automatic string tag(input logic [3:0] o);
        case (o)
            4'd0, 4'd1, 4'd2, 4'd3: return "R8";
            4'd4: return "R2";
            4'd5: return "R3";
            4'd6, 4'd7: return "R9";
            4'd8: return "R4";
            default: return "R5";
        endcase
    endfunction

    // Reference model working on exp_mem
    task automatic model(input logic [3:0] o, input logic [31:0] a, input logic [31:0] ro,
                         input logic [31:0] sd, input logic [4:0] di,
                         output logic [31:0] res, output int cnt);
        logic [3:0] x;
        int sh;
        x = a[3:0];
        res = ro;
        cnt = 0;
        case (o)
            4'd0, 4'd1: begin
                res = {24'd0, exp_mem[x]};
                if (o == 4'd0 && res[7]) res[31:8] = '1;
                cnt = 1;
            end
            4'd2, 4'd3: begin
                x[0] = 1'b0;
                res = {16'd0, exp_mem[x + 4'd1], exp_mem[x]};
                if (o == 4'd2 && res[15]) res[31:16] = '1;
                cnt = 2;
            end
            4'd4: begin
                sh = 24;
                forever begin
                    res[sh +: 8] = exp_mem[x]; cnt++;
                    if (x[1:0] == 2'b00) break;
                    x--; sh -= 8;
                end
            end
            4'd5: begin
                sh = 0;
                forever begin
                    res[sh +: 8] = exp_mem[x]; cnt++;
                    if (x[1:0] == 2'b11) break;
                    x++; sh += 8;
                end
            end
            4'd6: begin exp_mem[x] = sd[7:0]; cnt = 1; end
            4'd7: begin
                x[0] = 1'b0;
                exp_mem[x] = sd[7:0]; exp_mem[x + 4'd1] = sd[15:8]; cnt = 2;
            end
            4'd8: begin
                sh = 24;
                forever begin
                    exp_mem[x] = sd[sh +: 8]; cnt++;
                    if (x[1:0] == 2'b00) break;
                    x--; sh -= 8;
                end
            end
            default: begin
                sh = 0;
                forever begin
                    exp_mem[x] = sd[sh +: 8]; cnt++;
                    if (x[1:0] == 2'b11) break;
                    x++; sh += 8;
                end
            end
        endcase
        if (o <= 4'd5 && di == 5'd0) res = '0;
    endtask

    task automatic run_op(input logic [3:0] o, input logic [31:0] a, input logic [31:0] ro,
                          input logic [31:0] sd, input logic [4:0] di, input bit poke);
        logic [31:0] eres;
        int ecnt, cnt, wait_n;
        bit lane_ok, seen;
        model(o, a, ro, sd, di, eres, ecnt);
        @(negedge clk);
        op = o; eff_addr = a; reg_old = ro; store_data = sd; dst_idx = di; start = 1'b1;
        cnt = 0; wait_n = 0; lane_ok = 1'b1; seen = 1'b0;
        while (wait_n < 40) begin
            @(negedge clk);
            wait_n++;
            if (poke && wait_n == 1) begin
                op = 4'd6; eff_addr = 32'h0; store_data = 32'h5A; start = 1'b1;
            end else begin
                start = 1'b0;
            end
            if (mem_en) begin
                cnt++;
                if (mem_lane != (4'b0001 << mem_addr[1:0])) lane_ok = 1'b0;
            end
            if (done) begin seen = 1'b1; break; end
        end
        start = 1'b0;
        check(seen, "R11 done seen", 32'(seen), 32'd1);
        check(cnt == ecnt, $sformatf("%s byte count", tag(o)), cnt, ecnt);
        check(lane_ok, "R10 lane strobe", 32'(lane_ok), 32'd1);
        check(result == eres, $sformatf("%s result", tag(o)), result, eres);
        for (int i = 0; i < 16; i++)
            check(mem[i] == exp_mem[i], $sformatf("%s memory byte %0d", poke ? "R12" : tag(o), i),
                  32'(mem[i]), 32'(exp_mem[i]));
        @(negedge clk);
        check(!done, "R11 done one cycle", 32'(done), 32'd0);
        check(result == eres, "R11 result held", result, eres);
    endtask

    initial begin : watchdog
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 150000) begin
                fails++; tests++;
                $display("FAIL watchdog actual=%0d expected=<150000", cycles);
                $display("[TB] %0d tests run, %0d failed", tests, fails);
                $finish;
            end
        end
    end

    initial begin : main
        logic [31:0] r;
        bit any_en;
        r = $urandom(32'd7);
        for (int i = 0; i < 16; i++) begin
            mem[i] = 8'(i * 37 + 5);
            exp_mem[i] = mem[i];
        end
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check(!busy && !done && !mem_en, "R1 reset state", {busy, done, mem_en}, 32'd0);

        // R2 R3 R6: left/right loads from every offset with distinct old value
        for (int off = 0; off < 4; off++) begin
            run_op(4'd4, 32'h1000_0004 + off, 32'hA1B2C3D4, 32'h0, 5'd3, 1'b0);
            run_op(4'd5, 32'h2000_0008 + off, 32'h11223344, 32'h0, 5'd9, 1'b0);
        end
        // R4 R5: left/right stores from every offset
        for (int off = 0; off < 4; off++) begin
            run_op(4'd8, 32'h0000_000C + off, 32'h0, 32'hDEADBEEF ^ off, 5'd1, 1'b0);
            run_op(4'd9, 32'h0000_0000 + off, 32'h0, 32'hCAFEF00D + off, 5'd1, 1'b0);
        end
        // R8: sign and zero extension with MSB set and clear
        exp_mem[5] = 8'h80; mem[5] = 8'h80; exp_mem[6] = 8'h7F; mem[6] = 8'h7F;
        exp_mem[7] = 8'hF0; mem[7] = 8'hF0;
        run_op(4'd0, 32'd5, 32'hFFFF_FFFF, 0, 5'd2, 1'b0);
        run_op(4'd1, 32'd5, 32'hFFFF_FFFF, 0, 5'd2, 1'b0);
        run_op(4'd0, 32'd6, 32'hFFFF_FFFF, 0, 5'd2, 1'b0);
        run_op(4'd2, 32'd7, 32'h0, 0, 5'd2, 1'b0);   // odd address, bit 0 ignored
        run_op(4'd3, 32'd7, 32'h0, 0, 5'd2, 1'b0);
        run_op(4'd2, 32'd5, 32'h0, 0, 5'd2, 1'b0);
        // R9: byte and halfword stores
        run_op(4'd6, 32'd9, 32'h1234_5678, 32'h0000_00A5, 5'd4, 1'b0);
        run_op(4'd7, 32'd11, 32'h1234_5678, 32'h0000_C3E1, 5'd4, 1'b0);
        // R7: destination zero
        run_op(4'd4, 32'd3, 32'hFFFF_FFFF, 0, 5'd0, 1'b0);
        run_op(4'd0, 32'd5, 32'h0, 0, 5'd0, 1'b0);
        // R12: start while busy is ignored
        run_op(4'd5, 32'd4, 32'h0BAD_F00D, 0, 5'd6, 1'b1);

        // R12: undefined codes ignored
        for (int c = 10; c < 16; c++) begin
            @(negedge clk);
            op = 4'(c); eff_addr = 32'd2; store_data = 32'hFFFF_FFFF; start = 1'b1;
            any_en = 1'b0;
            for (int k = 0; k < 4; k++) begin
                @(negedge clk);
                start = 1'b0;
                if (mem_en || busy || done) any_en = 1'b1;
            end
            check(!any_en, "R12 undefined opcode", 32'(any_en), 32'd0);
        end
        for (int i = 0; i < 16; i++)
            check(mem[i] == exp_mem[i], "R12 memory after undefined", 32'(mem[i]), 32'(exp_mem[i]));

        // Random mix of all valid operations
        for (int n = 0; n < 200; n++) begin
            logic [3:0] ro;
            ro = 4'($urandom_range(0, 9));
            run_op(ro, {$urandom, 4'($urandom)} & 32'hFFFF_FFFF, $urandom, $urandom,
                   5'($urandom), 1'b0);
        end

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule